// File: doc/BRIEF.md
# Calendar Clock with Buffered Host Registers

This block is a real-time clock core. A one-cycle time-base enable, pulsed at 32.768 kHz, feeds a prescaler that closes a one-second period every `TICKS_PER_SEC` enables. At the end of each period the core runs a short update sequence. First it advances a private working copy of the time and calendar (seconds through century). In the following cycle it copies that working copy into a host-visible buffer, sets the update-ended flag, and compares the new time against four alarm bytes. An update-in-progress flag warns the host a fixed number of ticks before the sequence begins and drops once the copy has completed.

The host reaches fourteen byte registers through a synchronous port. A write strobe stores a byte on the clock edge. A read strobe returns a byte one cycle later. Time bytes read from the buffer, and a write to a time byte updates both copies. A control bit can freeze the buffer so that the host sees a stable snapshot while the working copy keeps counting. A second control bit selects whether time and alarm values are in BCD or in binary. The century is held beside the year in the low seven bits of control register A, in binary.

Top module: `rtc_core`

## Requirements
- R1: The seconds value advances by exactly one at the end of every `TICKS_PER_SEC` time-base enables, and it does not change between those points.
- R2: Bit 7 of register A (address 0xA) reads 1 from the `TICKS_PER_SEC-UIP_LEAD`-th enable of a period until the buffer copy. It reads 0 from the cycle after that copy.
- R3: The time fields count 0 to 59 for seconds (address 0x0) and minutes (0x2), and 0 to 23 for hours (0x4). Day of week (0x6) counts 1 to 7 and advances at midnight.
- R4: Date (0x7) rolls over after 31 days in months 1, 3, 5, 7, 8, 10 and 12, after 30 days in months 4, 6, 9 and 11, and after 28 days in month 2 (29 when year mod 4 is 0). Month (0x8) rolls from 12 to 1 and increments the year (0x9).
- R5: Year rolls from 99 to 0 and increments the century in bits 6:0 of register A (binary, written there). The century rolls from 99 to 0.
- R6: Bit 2 of register B (0xB) selects binary (1) or BCD (0). The selected format applies to time reads, time writes and the alarm compare.
- R7: After each update, the alarm flag (bit 5 of register C, 0xC) is set if every alarm byte (seconds 0x1, minutes 0x3, hours 0x5, date 0xD) equals the time field in the current format, or has bits 7:6 = 11. Bit 7 of register C and the `irq` output equal the alarm flag ANDed with the alarm enable (bit 5 of register B).
- R8: Bit 4 of register C is set by every update. A read of register C returns the flags and then clears them.
- R9: While bit 7 of register B is 1, the time bytes read back frozen and timekeeping continues. After the bit is cleared, the next update shows the fully advanced time.
- R10: While `rstN` is low, reads return 0 and writes are ignored. Reset clears the alarm enable and all register C flags. It leaves the time bytes and the other register B bits unchanged.
- R11: Read data appears on `rdData` in the cycle after `rdEn`. Addresses 0xE and 0xF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tickEn | input | 1 | 32.768 kHz time-base enable, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| irq | output | 1 | Alarm interrupt, high while flag and enable are both set |

## Verification
The bench shortens the second to 16 enables. It walks seconds and minutes through two full minutes. It then crosses midnight from every day of the week, and crosses the last day of every month across four consecutive years. This separates carry-chain errors from errors in the month-length and leap-year tables. Every seconds value is written in BCD and read back in both formats, and a BCD carry is crossed, which exposes coding slips. Alarms are tried with exact matches, a single mismatch, all-don't-care bytes, and a value that matches only when read as BCD. Freeze, the update-flag window edges and reset retention are each probed at the cycle they change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 7;

  localparam logic [ADDR_W-1:0] A_SEC      = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEC_ALM  = 4'h1;
  localparam logic [ADDR_W-1:0] A_MIN      = 4'h2;
  localparam logic [ADDR_W-1:0] A_MIN_ALM  = 4'h3;
  localparam logic [ADDR_W-1:0] A_HR       = 4'h4;
  localparam logic [ADDR_W-1:0] A_HR_ALM   = 4'h5;
  localparam logic [ADDR_W-1:0] A_DOW      = 4'h6;
  localparam logic [ADDR_W-1:0] A_DATE     = 4'h7;
  localparam logic [ADDR_W-1:0] A_MON      = 4'h8;
  localparam logic [ADDR_W-1:0] A_YEAR     = 4'h9;
  localparam logic [ADDR_W-1:0] A_CTLA     = 4'hA;
  localparam logic [ADDR_W-1:0] A_CTLB     = 4'hB;
  localparam logic [ADDR_W-1:0] A_FLAGS    = 4'hC;
  localparam logic [ADDR_W-1:0] A_DATE_ALM = 4'hD;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t cent, year, mon, date, dow, hr, min, sec;
  } rtcTime_t;

  typedef struct packed {
    logic advance;   // close of the one-second period
    logic transfer;  // copy working time to host buffer, run compares
  } rtcStrobe_t;

  function automatic field_t monthDays(field_t mon, field_t year);
    case (mon)
      7'd2:                    return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                 return 7'd31;
    endcase
  endfunction

  function automatic rtcTime_t nextTime(rtcTime_t t);
    rtcTime_t n;
    n = t;
    if (t.sec < 7'd59) n.sec = t.sec + 7'd1;
    else begin
      n.sec = '0;
      if (t.min < 7'd59) n.min = t.min + 7'd1;
      else begin
        n.min = '0;
        if (t.hr < 7'd23) n.hr = t.hr + 7'd1;
        else begin
          n.hr  = '0;
          n.dow = (t.dow >= 7'd7) ? 7'd1 : t.dow + 7'd1;
          if (t.date < monthDays(t.mon, t.year)) n.date = t.date + 7'd1;
          else begin
            n.date = 7'd1;
            if (t.mon < 7'd12) n.mon = t.mon + 7'd1;
            else begin
              n.mon = 7'd1;
              if (t.year < 7'd99) n.year = t.year + 7'd1;
              else begin
                n.year = '0;
                n.cent = (t.cent >= 7'd99) ? 7'd0 : t.cent + 7'd1;
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic field_t fromHost(logic [DATA_W-1:0] b, logic binMode);
    field_t tens;
    tens = field_t'(b[7:4]);
    return binMode ? b[6:0] : tens * 7'd10 + field_t'(b[3:0]);
  endfunction

  function automatic logic [DATA_W-1:0] toHost(field_t v, logic binMode);
    return binMode ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic rtcTime_t applyWrite(rtcTime_t t, logic [ADDR_W-1:0] a,
                                          logic [DATA_W-1:0] d, logic binMode);
    rtcTime_t n;
    n = t;
    case (a)
      A_SEC:   n.sec  = fromHost(d, binMode);
      A_MIN:   n.min  = fromHost(d, binMode);
      A_HR:    n.hr   = fromHost(d, binMode);
      A_DOW:   n.dow  = fromHost(d, binMode);
      A_DATE:  n.date = fromHost(d, binMode);
      A_MON:   n.mon  = fromHost(d, binMode);
      A_YEAR:  n.year = fromHost(d, binMode);
      A_CTLA:  n.cent = d[6:0];
      default: ;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  output rtcStrobe_t strobe,
  output logic       uip
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] RAISE = CW'(TICKS_PER_SEC - 1 - UIP_LEAD);

  logic [CW-1:0] tickCnt;
  logic          lastTick;
  logic          xferPend;

  assign lastTick = tickEn && (tickCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      xferPend <= 1'b0;
      uip      <= 1'b0;
    end else begin
      if (tickEn) tickCnt <= lastTick ? '0 : tickCnt + CW'(1);
      xferPend <= lastTick;
      if (tickEn && (tickCnt == RAISE)) uip <= 1'b1;
      else if (xferPend)                uip <= 1'b0;
    end
  end

  assign strobe.advance  = lastTick;
  assign strobe.transfer = xferPend;
endmodule

// File: rtl/rtc_data.sv
module rtc_data
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic              uip,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  rtcTime_t cur, usr, curNext, usrNext;
  logic [DATA_W-1:0] almSec, almMin, almHr, almDate;
  logic [1:0] ctlHi;   // bit 7 freeze, bit 6 spare
  logic [4:0] ctlLo;   // bit 2 binary mode, others spare
  logic aie, af, uf;
  logic hostWr, binMode, freeze, almHit;
  logic [DATA_W-1:0] readVal;

  assign hostWr  = wrEn & rstN;
  assign binMode = ctlLo[2];
  assign freeze  = ctlHi[1];

  function automatic logic almMatch(logic [DATA_W-1:0] raw, field_t v, logic bm);
    return (raw[7:6] == 2'b11) || (raw == toHost(v, bm));
  endfunction

  assign almHit = almMatch(almSec, cur.sec, binMode) & almMatch(almMin, cur.min, binMode)
                & almMatch(almHr, cur.hr, binMode) & almMatch(almDate, cur.date, binMode);

  always_comb begin
    curNext = strobe.advance ? nextTime(cur) : cur;
    usrNext = (strobe.transfer && !freeze) ? cur : usr;
    if (hostWr) begin
      curNext = applyWrite(curNext, addr, wrData, binMode);
      usrNext = applyWrite(usrNext, addr, wrData, binMode);
    end
  end

  // time keeps its value across reset
  always_ff @(posedge clk) begin
    cur <= curNext;
    usr <= usrNext;
  end

  always_ff @(posedge clk) begin
    if (hostWr) begin
      case (addr)
        A_SEC_ALM:  almSec  <= wrData;
        A_MIN_ALM:  almMin  <= wrData;
        A_HR_ALM:   almHr   <= wrData;
        A_DATE_ALM: almDate <= wrData;
        A_CTLB: begin
          ctlHi <= wrData[7:6];
          ctlLo <= wrData[4:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aie <= 1'b0;
      af  <= 1'b0;
      uf  <= 1'b0;
    end else begin
      if (wrEn && addr == A_CTLB) aie <= wrData[5];
      if (rdEn && addr == A_FLAGS) begin
        af <= 1'b0;
        uf <= 1'b0;
      end
      if (strobe.transfer) begin
        uf <= 1'b1;
        if (almHit) af <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      A_SEC:      readVal = toHost(usr.sec, binMode);
      A_MIN:      readVal = toHost(usr.min, binMode);
      A_HR:       readVal = toHost(usr.hr, binMode);
      A_DOW:      readVal = toHost(usr.dow, binMode);
      A_DATE:     readVal = toHost(usr.date, binMode);
      A_MON:      readVal = toHost(usr.mon, binMode);
      A_YEAR:     readVal = toHost(usr.year, binMode);
      A_SEC_ALM:  readVal = almSec;
      A_MIN_ALM:  readVal = almMin;
      A_HR_ALM:   readVal = almHr;
      A_DATE_ALM: readVal = almDate;
      A_CTLA:     readVal = {uip, usr.cent};
      A_CTLB:     readVal = {ctlHi, aie, ctlLo};
      A_FLAGS:    readVal = {af & aie, 1'b0, af, uf, 4'b0000};
      default:    readVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= readVal;
  end

  assign irq = af & aie;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  rtcStrobe_t strobe;
  logic       uip;

  rtc_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_LEAD     (UIP_LEAD)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .tickEn(tickEn),
    .strobe(strobe),
    .uip   (uip)
  );

  rtc_data u_data (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .uip   (uip),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .wrData(wrData),
    .rdData(rdData),
    .irq   (irq)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              irq,
  input rtcStrobe_t        strobe,
  input logic              uip
);
  assert_adv_then_xfer_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> strobe.transfer);

  assert_uip_covers_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> uip);

  assert_uip_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.transfer |=> !uip);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(strobe.transfer) || $past(wrEn && addr == A_CTLB)));

  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_FLAGS && !strobe.transfer) |=> !irq);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (rdData == '0 && !irq));
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .addr  (addr),
  .rdData(rdData),
  .irq   (irq),
  .strobe(strobe),
  .uip   (uip)
);

// File: tb/test_rtc_core.sv
module test_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int TPS  = 16;
  localparam int LEAD = 4;

  logic       clk = 1'b0;
  logic       rstN, tickEn, wrEn, rdEn;
  logic [3:0] addr;
  logic [7:0] wrData, rdData;
  logic       irq;
  int tests = 0;
  int fails = 0;

  rtc_core #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) i_rtc_core (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int toBcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int daysIn(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    addr = 4'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 4'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = int'(rdData);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      tickEn = 1'b1;
      @(negedge clk);
    end
    tickEn = 1'b0;
  endtask

  task automatic second();
    tick(TPS);
    idle(2);
  endtask

  task automatic setTime(input bit bcd, input int y, input int mo, input int d,
                         input int dw, input int h, input int mi, input int s);
    wr(9, bcd ? toBcd(y)  : y);
    wr(8, bcd ? toBcd(mo) : mo);
    wr(7, bcd ? toBcd(d)  : d);
    wr(6, bcd ? toBcd(dw) : dw);
    wr(4, bcd ? toBcd(h)  : h);
    wr(2, bcd ? toBcd(mi) : mi);
    wr(0, bcd ? toBcd(s)  : s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    rstN = 1'b0; tickEn = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    idle(3);
    rd(12, v); chk("R10 read during reset", v, 0);
    rstN = 1'b1;
    idle(1);
    rd(12, v); chk("R8 flags after reset", v, 0);
    chk("R7 irq after reset", int'(irq), 0);
    rd(14, v); chk("R11 unused 0xE", v, 0);
    rd(15, v); chk("R11 unused 0xF", v, 0);

    // binary mode, no freeze, alarm enable off
    wr(11, 8'h04);
    setTime(0, 21, 3, 10, 2, 0, 0, 5);
    tick(TPS - 1); idle(2);
    rd(0, v); chk("R1 no change mid-period", v, 5);
    tick(1); idle(2);
    rd(0, v); chk("R1 advance at period end", v, 6);

    // two-minute sweep of seconds and minutes
    setTime(0, 21, 3, 10, 2, 0, 0, 0);
    for (int i = 1; i <= 120; i++) begin
      second();
      rd(0, v); chk("R1 R3 seconds sweep", v, i % 60);
      rd(2, v); chk("R3 minutes sweep", v, i / 60);
    end

    // update-in-progress window
    tick(TPS - LEAD - 1);
    rd(10, v); chk("R2 uip low before window", v >> 7, 0);
    tick(1);
    rd(10, v); chk("R2 uip high at window start", v >> 7, 1);
    tick(LEAD - 1);
    rd(10, v); chk("R2 uip high before update", v >> 7, 1);
    tick(1); idle(1);
    rd(10, v); chk("R2 uip low after copy", v >> 7, 0);

    // midnight from every weekday
    for (int d = 1; d <= 7; d++) begin
      setTime(0, 30, 5, 10, d, 23, 59, 59);
      second();
      rd(4, v); chk("R3 hour wrap", v, 0);
      rd(2, v); chk("R3 minute wrap", v, 0);
      rd(6, v); chk("R3 weekday advance", v, (d % 7) + 1);
      rd(7, v); chk("R3 date mid-month", v, 11);
    end

    // month ends across a leap cycle
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        setTime(0, y, m, daysIn(m, y) - 1, 1, 23, 59, 59);
        second();
        rd(7, v); chk("R4 day before month end", v, daysIn(m, y));
        setTime(0, y, m, daysIn(m, y), 1, 23, 59, 59);
        second();
        rd(7, v); chk("R4 date wraps", v, 1);
        rd(8, v); chk("R4 month advance", v, (m % 12) + 1);
        rd(9, v); chk("R4 year at month wrap", v, (m == 12) ? y + 1 : y);
      end
    end

    // century
    setTime(0, 99, 12, 31, 3, 23, 59, 59);
    wr(10, 19);
    second();
    rd(9, v);  chk("R5 year wraps", v, 0);
    rd(10, v); chk("R5 century increments", v & 8'h7f, 20);
    setTime(0, 99, 12, 31, 3, 23, 59, 59);
    wr(10, 99);
    second();
    rd(10, v); chk("R5 century wraps", v & 8'h7f, 0);

    // BCD / binary formats
    for (int s = 0; s < 60; s++) begin
      wr(11, 8'h00);
      wr(0, toBcd(s));
      rd(0, v); chk("R6 bcd readback", v, toBcd(s));
      wr(11, 8'h04);
      rd(0, v); chk("R6 binary view of bcd write", v, s);
    end
    wr(11, 8'h00);
    setTime(1, 5, 6, 7, 2, 9, 9, 59);
    second();
    rd(0, v); chk("R6 bcd seconds carry", v, 8'h00);
    rd(2, v); chk("R6 bcd minutes carry", v, 8'h10);

    // alarms, binary
    wr(11, 8'h24);
    setTime(0, 5, 6, 10, 2, 10, 20, 30);
    wr(1, 31); wr(3, 20); wr(5, 10); wr(13, 10);
    rd(12, v);
    second();
    chk("R7 irq on match", int'(irq), 1);
    rd(12, v); chk("R7 flags on match", v, 8'hb0);
    chk("R8 irq cleared by read", int'(irq), 0);
    rd(12, v); chk("R8 flags cleared by read", v, 0);
    wr(1, 0);
    second();
    rd(12, v); chk("R7 mismatch gives update flag only", v, 8'h10);
    wr(11, 8'h04);
    wr(1, 8'hc0); wr(3, 8'hc5); wr(5, 8'hff); wr(13, 8'hc0);
    second();
    chk("R7 irq off without enable", int'(irq), 0);
    rd(12, v); chk("R7 dont-care match", v, 8'h30);

    // alarms, BCD
    wr(11, 8'h20);
    setTime(1, 5, 6, 25, 2, 12, 34, 56);
    wr(1, 8'h57); wr(3, 8'h34); wr(5, 8'h12); wr(13, 8'h25);
    rd(12, v);
    second();
    rd(12, v); chk("R7 R6 bcd alarm match", v, 8'hb0);
    wr(1, 57);
    second();
    rd(12, v); chk("R7 R6 binary value misses in bcd", v, 8'h10);

    // freeze
    wr(11, 8'h84);
    setTime(0, 5, 6, 10, 2, 8, 0, 10);
    second(); second();
    rd(0, v); chk("R9 frozen seconds", v, 10);
    wr(11, 8'h04);
    rd(0, v); chk("R9 still frozen until update", v, 10);
    second();
    rd(0, v); chk("R9 catches up after release", v, 13);

    // reset retention
    wr(11, 8'h24);
    wr(1, 8'hc0); wr(3, 8'hc0); wr(5, 8'hc0); wr(13, 8'hc0);
    setTime(0, 5, 6, 10, 2, 8, 0, 6);
    second();
    chk("R7 irq before reset", int'(irq), 1);
    rstN = 1'b0;
    idle(1);
    rd(0, v); chk("R10 reads zero in reset", v, 0);
    wr(0, 40);
    wr(11, 8'h00);
    rstN = 1'b1;
    idle(1);
    chk("R10 irq cleared", int'(irq), 0);
    rd(0, v);  chk("R10 time kept, write ignored", v, 7);
    rd(11, v); chk("R10 enable cleared, mode kept", v, 8'h04);
    rd(12, v); chk("R10 flags cleared", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule